// File: doc/BRIEF.md
# RF Transmitter Keying Sequencer

This block controls an external RF transmitter through three lines: an oscillator enable that starts the crystal oscillator, PLL and clock output; an amplifier enable that powers the output stage; and a switch line that pulls the crystal load to shift frequency. A start pulse brings the transmitter out of standby. The oscillator enable comes up first. A programmable settling time then runs before the amplifier may turn on, and it is counted on the local system clock because the transmitter's clock is not yet valid at that point.

Once the settling time has passed, the sequencer shifts out a serial telegram of up to 64 bits, most significant bit first. The bit period is taken from the transmitter's clock output, which arrives on `ref_clk`. That input is synchronised into the system clock domain, and its rising edges are counted against a 16-bit divisor, so the data-rate accuracy follows the crystal. With amplitude keying, the amplifier enable follows each data bit. With frequency keying, the amplifier stays on and the data bit drives the crystal pull switch. After the final bit, both enables drop back to standby and a one-cycle done pulse is given.

Top module: `rf_key_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `osc_en`, `pa_en`, `fsk_sw` and `done` are all low.
- R2: A `start` pulse while idle raises `osc_en` and `busy` on the next clock cycle.
- R3: After `osc_en` rises, `pa_en` stays low and `osc_en` stays high for exactly `settle_cycles`+1 system-clock cycles. The first bit starts in the cycle after that.
- R4: Each bit lasts `bit_div` rising edges of `ref_clk`. A divisor of 0 acts as 1.
- R5: Bits are sent from `payload[len-1]` down to `payload[0]`, most significant first.
- R6: In amplitude mode (`fsk_mode`=0), `pa_en` is high for a 1 bit and low for a 0 bit, and `fsk_sw` stays low.
- R7: In frequency mode (`fsk_mode`=1), `pa_en` stays high for every bit of the telegram, and `fsk_sw` equals the current bit.
- R8: After the last bit, `osc_en` and `pa_en` fall together. `done` is high for exactly that one cycle, and `busy` is low in the following cycle.
- R9: A `start` pulse while `busy` is high is ignored. The telegram in progress is not altered, and no second telegram follows.
- R10: A `bit_len` of 0 returns to standby right after the settling time, and `pa_en` is never raised.
- R11: A `bit_len` above 64 is treated as 64.
- R12: Mode, payload, length, settling time and divisor are captured at `start`. Later changes to those inputs do not affect the telegram in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Clock output of the transmitter, asynchronous to `clk` |
| start | input | 1 | Begin a telegram when idle |
| fsk_mode | input | 1 | 0 = amplitude keying, 1 = frequency keying |
| payload | input | 64 | Telegram bits, sent from bit `bit_len-1` down to bit 0 |
| bit_len | input | 7 | Number of bits to send (0 to 64; larger values are clamped) |
| settle_cycles | input | 24 | Settling delay in system-clock cycles |
| bit_div | input | 16 | Reference-clock edges per bit |
| osc_en | output | 1 | Oscillator/PLL enable to the transmitter |
| pa_en | output | 1 | Power amplifier enable to the transmitter |
| fsk_sw | output | 1 | Crystal load pull switch control |
| busy | output | 1 | High from start acceptance until the done cycle |
| done | output | 1 | One-cycle pulse as the transmitter returns to standby |

## Verification
Some rules can be checked on every cycle, and assertions do that. They hold the outputs in standby while idle, allow the amplifier only while the oscillator is enabled, and require the settling gap before the first amplifier rise. They also check that the amplifier never drops mid-telegram in frequency mode, and that `done` lasts one cycle and only in standby. Other behaviour only the bench scenarios can show: the bit order, the bit period derived from the reference clock, clamping of the length, capture of the inputs at start, and rejection of a start while busy. The bench shows these by sampling each bit near its middle and comparing it against values held in its scoreboard.

// File: rtl/rfks_pkg.sv
package rfks_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SEND   = 2'd2,
        ST_STOP   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic osc;
        logic pa;
        logic sw;
    } key_lines_t;

    // Line levels for a given state, keying mode and current data bit.
    function automatic key_lines_t lines_for(input seq_state_t st,
                                             input logic fsk,
                                             input logic data_bit);
        key_lines_t k;
        k.osc = (st == ST_SETTLE) || (st == ST_SEND);
        k.pa  = (st == ST_SEND) && (fsk || data_bit);
        k.sw  = (st == ST_SEND) && fsk && data_bit;
        return k;
    endfunction

endpackage

// File: rtl/rfks_ref_sync.sv
module rfks_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic ref_rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ref_async};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign ref_rise = chain_q[STAGES-1] && !last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> !ref_rise) else $error("rise pulse longer than one cycle"); // R4
endmodule

// File: rtl/rfks_settle_timer.sv
module rfks_settle_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/rfks_bit_timer.sv
module rfks_bit_timer #(
    parameter int DIV_W = 16,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    input  logic             ref_rise,
    output logic [IDX_W-1:0] idx,
    output logic             last_end
);
    logic [DIV_W-1:0] edge_q;
    logic [IDX_W-1:0] idx_q;
    logic [DIV_W-1:0] div_eff;
    logic             wrap;

    assign div_eff  = (div == '0) ? DIV_W'(1) : div;
    assign wrap     = run && ref_rise && ((edge_q + DIV_W'(1)) >= div_eff);
    assign last_end = wrap && (idx_q == '0);
    assign idx      = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            edge_q <= '0;
            idx_q  <= first_idx;
        end else if (run && ref_rise) begin
            if (wrap) begin
                edge_q <= '0;
                if (idx_q != '0) idx_q <= idx_q - IDX_W'(1);
            end else begin
                edge_q <= edge_q + DIV_W'(1);
            end
        end
    end

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (edge_q < div_eff)) else $error("edge count past divisor"); // R4
endmodule

// File: rtl/rf_key_seq.sv
module rf_key_seq
    import rfks_pkg::*;
#(
    parameter int PAY_W   = 64,
    parameter int LEN_W   = 7,
    parameter int SET_W   = 24,
    parameter int DIV_W   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_clk,
    input  logic             start,
    input  logic             fsk_mode,
    input  logic [PAY_W-1:0] payload,
    input  logic [LEN_W-1:0] bit_len,
    input  logic [SET_W-1:0] settle_cycles,
    input  logic [DIV_W-1:0] bit_div,
    output logic             osc_en,
    output logic             pa_en,
    output logic             fsk_sw,
    output logic             busy,
    output logic             done
);
    localparam int IDX_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;

    seq_state_t       st_q;
    logic             fsk_q;
    logic [PAY_W-1:0] pay_q;
    logic [LEN_W-1:0] len_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_clamped;
    logic             ref_rise;
    logic             settle_done;
    logic             last_end;
    logic [IDX_W-1:0] bit_idx;
    logic             enter_send;
    key_lines_t       lines;

    assign len_clamped = (bit_len > LEN_W'(PAY_W)) ? LEN_W'(PAY_W) : bit_len;
    assign enter_send  = settle_done && (len_q != '0);

    rfks_ref_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ref_async (ref_clk),
        .ref_rise  (ref_rise)
    );

    rfks_settle_timer #(.CNT_W(SET_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (st_q == ST_IDLE && start),
        .load_val (settle_cycles),
        .run      (st_q == ST_SETTLE),
        .expired  (settle_done)
    );

    rfks_bit_timer #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .load      (enter_send),
        .first_idx (IDX_W'(len_q - LEN_W'(1))),
        .div       (div_q),
        .run       (st_q == ST_SEND),
        .ref_rise  (ref_rise),
        .idx       (bit_idx),
        .last_end  (last_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            fsk_q <= 1'b0;
            pay_q <= '0;
            len_q <= '0;
            div_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    fsk_q <= fsk_mode;
                    pay_q <= payload;
                    len_q <= len_clamped;
                    div_q <= bit_div;
                    st_q  <= ST_SETTLE;
                end
                ST_SETTLE: if (settle_done) begin
                    st_q <= (len_q == '0) ? ST_STOP : ST_SEND;
                end
                ST_SEND: if (last_end) begin
                    st_q <= ST_STOP;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign lines  = lines_for(st_q, fsk_q, pay_q[bit_idx]);
    assign osc_en = lines.osc;
    assign pa_en  = lines.pa;
    assign fsk_sw = lines.sw;
    assign busy   = (st_q != ST_IDLE);
    assign done   = (st_q == ST_STOP);

    // Checker state: cycles the oscillator enable has been high, saturating.
    logic [SET_W:0] osc_age_q;
    logic [SET_W-1:0] set_cap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            osc_age_q <= '0;
            set_cap_q <= '0;
        end else begin
            if (!busy && start) set_cap_q <= settle_cycles;
            if (!osc_en) osc_age_q <= '0;
            else if (osc_age_q != '1) osc_age_q <= osc_age_q + (SET_W+1)'(1);
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!osc_en && !pa_en && !fsk_sw && !done)) else $error("idle not standby"); // R1
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (osc_en && busy)) else $error("start not taken"); // R2
    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(pa_en) |-> (osc_age_q > {1'b0, set_cap_q})) else $error("amplifier before settling"); // R3
    AST_PA_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        pa_en |-> osc_en) else $error("amplifier without oscillator"); // R3
    AST_SW_NEEDS_PA: assert property (@(posedge clk) disable iff (rst)
        fsk_sw |-> pa_en) else $error("pull switch without amplifier"); // R7
    AST_FSK_PA_HELD: assert property (@(posedge clk) disable iff (rst)
        (fsk_q && $fell(pa_en)) |-> !osc_en) else $error("amplifier dropped mid telegram"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) else $error("done not single cycle"); // R8
    AST_DONE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!osc_en && !pa_en && !fsk_sw)) else $error("done while lines active"); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy) else $error("busy dropped early"); // R9
endmodule

// File: tb/sim_rf_key_seq.sv
module sim_rf_key_seq;

    typedef struct {
        logic        fsk;
        int          len;
        logic [63:0] pay;
        int          settle;
        int          div;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk = 1'b0;
    logic        start = 1'b0;
    logic        fsk_mode = 1'b0;
    logic [63:0] payload = '0;
    logic [6:0]  bit_len = '0;
    logic [23:0] settle_cycles = '0;
    logic [15:0] bit_div = '0;
    logic        osc_en, pa_en, fsk_sw, busy, done;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    initial begin
        #1;
        forever #12 ref_clk = ~ref_clk;
    end

    rf_key_seq u0 (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .start(start),
        .fsk_mode(fsk_mode), .payload(payload), .bit_len(bit_len),
        .settle_cycles(settle_cycles), .bit_div(bit_div),
        .osc_en(osc_en), .pa_en(pa_en), .fsk_sw(fsk_sw),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: pushes the expected telegram, then issues the start pulse.
    task automatic send(input logic fsk, input int len, input logic [63:0] pay,
                        input int settle, input int div, input bit interfere);
        exp_t e;
        e.fsk = fsk; e.len = (len > 64) ? 64 : len; e.pay = pay;
        e.settle = settle; e.div = div;
        sb_q.push_back(e);
        @(negedge clk);
        fsk_mode = fsk; payload = pay; bit_len = 7'(len);
        settle_cycles = 24'(settle); bit_div = 16'(div); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(osc_en && busy, "R2 start accepted", {osc_en, busy}, 3);
        // R12: scramble inputs after capture
        fsk_mode = ~fsk; payload = ~pay; bit_len = 7'd3;
        settle_cycles = 24'd1; bit_div = 16'd1;
        if (interfere) begin
            repeat (settle + 10) @(negedge clk);
            start = 1'b1; payload = 64'h0123_4567_89AB_CDEF; fsk_mode = ~fsk;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(!osc_en && !busy, "R9 no second telegram", {osc_en, busy}, 0);
    endtask

    // Monitor: pops expected telegram when the oscillator enable comes up.
    task automatic observe(input exp_t e);
        bit settle_ok = 1;
        int off;
        int waited;
        for (int i = 0; i <= e.settle; i++) begin
            if (!(osc_en && !pa_en && busy)) settle_ok = 0;
            @(negedge clk);
        end
        chk(settle_ok, "R3 settling gap", settle_ok, 1);
        if (e.len == 0) begin
            chk(!osc_en && !pa_en && done, "R10 zero length standby",
                {osc_en, pa_en, done}, 1);
        end else begin
            off = 3 * (e.div - 1);
            repeat (off) @(negedge clk);
            for (int k = 0; k < e.len; k++) begin
                logic b;
                b = e.pay[e.len - 1 - k];
                if (e.fsk) begin
                    chk(pa_en === 1'b1 && osc_en === 1'b1, "R7 FSK amplifier held", pa_en, 1);
                    chk(fsk_sw === b, "R5 R7 FSK switch bit", fsk_sw, b);
                end else begin
                    chk(pa_en === b && osc_en === 1'b1, "R4 R5 R6 ASK amplifier bit", pa_en, b);
                    chk(fsk_sw === 1'b0, "R6 switch low in ASK", fsk_sw, 0);
                end
                if (k != e.len - 1) repeat (6 * e.div) @(negedge clk);
            end
            waited = 0;
            while (osc_en && waited < 6 * e.div) begin
                @(negedge clk);
                waited++;
            end
            chk(!osc_en && !pa_en && !fsk_sw && done, "R8 end standby with done",
                {osc_en, pa_en, fsk_sw, done}, 1);
        end
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
    endtask

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && osc_en) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R9 unexpected telegram", 1, 0);
                    while (osc_en) @(negedge clk);
                end else begin
                    e = sb_q.pop_front();
                    observe(e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!osc_en && !pa_en && !fsk_sw && !busy && !done, "R1 reset state",
            {osc_en, pa_en, fsk_sw, busy, done}, 0);
        send(1'b0, 8, 64'hA5, 50, 4, 0);
        send(1'b1, 8, 64'h3C, 20, 6, 0);
        send(1'b0, 0, 64'hFF, 10, 4, 0);
        send(1'b1, 100, 64'h8F0F_1234_5678_ABC1, 12, 4, 0);  // R11
        send(1'b0, 5, 64'h16, 30, 5, 1);                     // R9 R12
        send(1'b1, 1, 64'h0, 8, 4, 0);
        send(1'b0, 6, 64'h2B, 0, 4, 0);
        repeat (20) @(negedge clk);
        chk(sb_q.size() == 0, "R12 all telegrams observed", sb_q.size(), 0);
        chk(!osc_en && !pa_en && !fsk_sw, "R1 final standby", {osc_en, pa_en, fsk_sw}, 0);
        finish_run();
    end

endmodule